// File: doc/BRIEF.md
# Byte/Word Integer ALU with Flags Word

This block is the integer arithmetic stage of an 8/16-bit processor datapath. Each cycle in which `op_valid` is high it takes a destination operand, a source operand, a 3-bit operation selector and the current 16-bit flags word. One clock edge later it presents the computed value, a write strobe for that value, and the new flags word. A byte/word select picks the operating width. A sign-extend control widens an 8-bit immediate when the block works on words.

A separate step path increments or decrements the destination operand. That path ignores the operation selector and follows its own flag policy. The flags word keeps its direction, interrupt and trace bits unchanged and always leaves with its reserved positions at their fixed values.

The decoder drives the block directly. It feeds back the registered flags word, or any other architectural copy of it, as `flags_in` for the next operation.

Top module: `alu_flags_unit`

## Requirements
- R1: `op_code` selects 000 add, 001 or, 010 add-with-carry, 011 subtract-with-borrow, 100 and, 101 subtract, 110 xor, 111 compare. `res_out` is the result truncated to the selected width. In byte mode (`word_mode`=0) only the low 8 bits of each operand are used and `res_out[15:8]` is 0.
- R2: Compare computes destination minus source and updates the flags exactly as subtract does. `res_we` stays 0.
- R3: Add-with-carry adds `flags_in[0]`. Subtract-with-borrow also subtracts `flags_in[0]`. The other operations ignore it.
- R4: C (bit 0) is the carry out of, or the borrow into, the top bit of the selected width. A (bit 4) is the carry or borrow between bit 3 and bit 4.
- R5: Z (bit 6) is set when all result bits of the selected width are 0. S (bit 7) is the top bit of the result. P (bit 2) is set when bits 7..0 of the result hold an even number of ones, in both widths.
- R6: O (bit 11) is set when the signed result of an add or subtract does not fit the selected width.
- R7: Or, and, and xor clear O, C and A.
- R8: With `step_sel`=1, the result is the destination plus 1, or minus 1 when `step_down`=1. O, S, Z, A and P are updated, C is copied from `flags_in[0]`, and `res_we` is 1.
- R9: With `word_mode`=1 and `sext_imm`=1, the source is replaced by bit 7 of `src_opd` repeated into bits 15..8. In byte mode `sext_imm` has no effect.
- R10: Bits 10, 9 and 8 (direction, interrupt, trace) pass from `flags_in`. Bits 15..12 and 1 are always 1. Bits 5 and 3 are always 0, whatever `flags_in` holds.
- R11: Outputs are registered with one cycle of latency. In a cycle with `op_valid`=0, `res_we` becomes 0 and `res_out` and `flags_out` hold.
- R12: While reset is asserted, and after it, before any operation: `res_out`=0, `res_we`=0, `flags_out`=16'hF002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation strobe and output register enable |
| op_code | input | 3 | Two-operand operation selector |
| step_sel | input | 1 | Selects increment/decrement instead of `op_code` |
| step_down | input | 1 | Decrement when stepping |
| word_mode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| sext_imm | input | 1 | Sign-extend an 8-bit source in word mode |
| dst_opd | input | 16 | Destination operand |
| src_opd | input | 16 | Source operand |
| flags_in | input | 16 | Current flags word |
| res_out | output | 16 | Registered result |
| res_we | output | 1 | Registered result write strobe |
| flags_out | output | 16 | Registered new flags word |

## Verification
The properties assume that every input is known while `op_valid` is high, that `flags_in` is steady across the sampling edge, and that `op_code` carries no meaning while `step_sel` is high. They judge only what the registered outputs show one edge after an operation. The stimulus changes inputs only on the falling edge and always drives all of them to defined values. It keeps operations away from the reset-release window, so that no operation lands while the internal reset is still held. The bench sweeps flags words that contain junk in the reserved positions, so that their forcing is exercised without breaking these assumptions.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int FLAG_W = 16;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_OR  = 3'b001,
    OP_ADC = 3'b010,
    OP_SBB = 3'b011,
    OP_AND = 3'b100,
    OP_SUB = 3'b101,
    OP_XOR = 3'b110,
    OP_CMP = 3'b111
  } alu_op_e;

  // flag positions inside the flags word
  localparam int FB_C = 0;
  localparam int FB_P = 2;
  localparam int FB_A = 4;
  localparam int FB_Z = 6;
  localparam int FB_S = 7;
  localparam int FB_O = 11;

  // reserved positions and their fixed values
  localparam logic [FLAG_W-1:0] RSV_MASK = 16'hF02A;
  localparam logic [FLAG_W-1:0] RSV_ONES = 16'hF002;

  function automatic logic op_is_logic(input alu_op_e op);
    return (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_sub(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

  function automatic logic op_uses_carry(input alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/alu_src_ext.sv
module alu_src_ext #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          word_mode,
  input  logic          sext_imm,
  input  logic [DW-1:0] src_raw,
  output logic [DW-1:0] src_eff
);
  localparam int HW = DW - NW;

  always_comb begin
    if (!word_mode) begin
      src_eff = {{HW{1'b0}}, src_raw[NW-1:0]};
    end else if (sext_imm) begin
      src_eff = {{HW{src_raw[NW-1]}}, src_raw[NW-1:0]};
    end else begin
      src_eff = src_raw;
    end
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_flags_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  alu_op_e       op,
  input  logic          step_en,
  input  logic          step_down,
  input  logic          word_mode,
  input  logic          carry_in,
  input  logic [DW-1:0] opd_a,
  input  logic [DW-1:0] opd_b,
  output logic [DW-1:0] res,
  output logic          logic_cls,
  output logic          carry_out,
  output logic          aux_out,
  output logic          ovf_out
);
  localparam int NIB = 4;
  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] a_m, b_m, lres, ares, aux_vec;
  logic [DW:0]   raw;
  logic          sub, ci, sa, sb, sr;

  always_comb begin
    a_m = word_mode ? opd_a : (opd_a & NMASK);
    if (step_en) begin
      b_m       = ONE;
      sub       = step_down;
      ci        = 1'b0;
      logic_cls = 1'b0;
    end else begin
      b_m       = word_mode ? opd_b : (opd_b & NMASK);
      sub       = op_is_sub(op);
      ci        = op_uses_carry(op) & carry_in;
      logic_cls = op_is_logic(op);
    end

    // one shared adder/subtractor, one bit wider than a word
    if (sub) raw = {1'b0, a_m} - {1'b0, b_m} - {{DW{1'b0}}, ci};
    else     raw = {1'b0, a_m} + {1'b0, b_m} + {{DW{1'b0}}, ci};

    ares = word_mode ? raw[DW-1:0] : (raw[DW-1:0] & NMASK);

    case (op)
      OP_OR:   lres = a_m | b_m;
      OP_AND:  lres = a_m & b_m;
      default: lres = a_m ^ b_m;
    endcase

    res       = logic_cls ? lres : ares;
    carry_out = word_mode ? raw[DW] : raw[NW];
    aux_vec   = a_m ^ b_m ^ ares;
    aux_out   = aux_vec[NIB];

    sa = word_mode ? a_m[DW-1]  : a_m[NW-1];
    sb = word_mode ? b_m[DW-1]  : b_m[NW-1];
    sr = word_mode ? ares[DW-1] : ares[NW-1];
    if (sub) ovf_out = (sa != sb) && (sr != sa);
    else     ovf_out = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_flag_build.sv
module alu_flag_build
  import alu_flags_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic              logic_cls,
  input  logic              step_cls,
  input  logic              word_mode,
  input  logic [DW-1:0]     res,
  input  logic              carry,
  input  logic              aux,
  input  logic              ovf,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_next
);
  localparam int PW = 8;

  logic zf, sf, pf;
  logic [FLAG_W-1:0] f;

  always_comb begin
    zf = word_mode ? (res == '0) : (res[NW-1:0] == '0);
    sf = word_mode ? res[DW-1] : res[NW-1];
    pf = ~(^res[PW-1:0]);

    f        = flags_in;
    f[FB_Z]  = zf;
    f[FB_S]  = sf;
    f[FB_P]  = pf;
    f[FB_O]  = ovf;
    f[FB_A]  = aux;
    f[FB_C]  = carry;
    if (step_cls) begin
      f[FB_C] = flags_in[FB_C];
    end
    if (logic_cls) begin
      f[FB_O] = 1'b0;
      f[FB_A] = 1'b0;
      f[FB_C] = 1'b0;
    end
    flags_next = (f & ~RSV_MASK) | RSV_ONES;
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              step_sel,
  input  logic              step_down,
  input  logic              word_mode,
  input  logic              sext_imm,
  input  logic [DW-1:0]     dst_opd,
  input  logic [DW-1:0]     src_opd,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DW-1:0]     res_out,
  output logic              res_we,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int SYNC_N = 2;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[SYNC_N-1];

  alu_op_e           op;
  logic [DW-1:0]     src_eff, res_c;
  logic              logic_cls, carry_c, aux_c, ovf_c;
  logic [FLAG_W-1:0] flags_c;

  assign op = alu_op_e'(op_code);

  alu_src_ext #(.DW(DW), .NW(NW)) u_ext (
    .word_mode (word_mode),
    .sext_imm  (sext_imm),
    .src_raw   (src_opd),
    .src_eff   (src_eff)
  );

  alu_arith #(.DW(DW), .NW(NW)) u_arith (
    .op        (op),
    .step_en   (step_sel),
    .step_down (step_down),
    .word_mode (word_mode),
    .carry_in  (flags_in[FB_C]),
    .opd_a     (dst_opd),
    .opd_b     (src_eff),
    .res       (res_c),
    .logic_cls (logic_cls),
    .carry_out (carry_c),
    .aux_out   (aux_c),
    .ovf_out   (ovf_c)
  );

  alu_flag_build #(.DW(DW), .NW(NW)) u_flags (
    .logic_cls  (logic_cls),
    .step_cls   (step_sel),
    .word_mode  (word_mode),
    .res        (res_c),
    .carry      (carry_c),
    .aux        (aux_c),
    .ovf        (ovf_c),
    .flags_in   (flags_in),
    .flags_next (flags_c)
  );

  // next state
  logic [DW-1:0]     res_d;
  logic              we_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    res_d   = res_out;
    flags_d = flags_out;
    we_d    = 1'b0;
    if (op_valid) begin
      res_d   = res_c;
      flags_d = flags_c;
      we_d    = step_sel || (op != OP_CMP);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_out   <= '0;
      res_we    <= 1'b0;
      flags_out <= RSV_ONES;
    end else begin
      res_out   <= res_d;
      res_we    <= we_d;
      flags_out <= flags_d;
    end
  end
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          step_sel,
  input logic          word_mode,
  input logic [15:0]   flags_in,
  input logic [DW-1:0] res_out,
  input logic          res_we,
  input logic [15:0]   flags_out
);
  // R2
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !step_sel && op_code == 3'b111) |=> !res_we);

  // R7
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !step_sel && (op_code == 3'b001 || op_code == 3'b100 || op_code == 3'b110))
    |=> (flags_out[11] == 1'b0 && flags_out[4] == 1'b0 && flags_out[0] == 1'b0));

  // R8
  step_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && step_sel) |=> (flags_out[0] == $past(flags_in[0]) && res_we));

  // R10
  ctrl_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> (flags_out[10:8] == $past(flags_in[10:8])));

  // R10
  reserved_fixed_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> (flags_out[15:12] == 4'hF && flags_out[5] == 1'b0 &&
                  flags_out[3] == 1'b0 && flags_out[1] == 1'b1));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> (!res_we && $stable(flags_out) && $stable(res_out)));

  // R1
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !word_mode) |=> (res_out[DW-1:8] == '0));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && (step_sel || op_code != 3'b111)) |=> (flags_out[6] == (res_out == '0)));
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .step_sel  (step_sel),
  .word_mode (word_mode),
  .flags_in  (flags_in),
  .res_out   (res_out),
  .res_we    (res_we),
  .flags_out (flags_out)
);

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;
  logic        clk;
  logic        rst_n;
  logic        op_valid, step_sel, step_down, word_mode, sext_imm;
  logic [2:0]  op_code;
  logic [15:0] dst_opd, src_opd, flags_in;
  logic [15:0] res_out, flags_out;
  logic        res_we;

  int n_checks = 0;
  int n_fails  = 0;

  localparam int WATCHDOG_CYC = 180000;

  alu_flags_unit i_alu_flags_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .step_sel(step_sel), .step_down(step_down), .word_mode(word_mode),
    .sext_imm(sext_imm), .dst_opd(dst_opd), .src_opd(src_opd),
    .flags_in(flags_in), .res_out(res_out), .res_we(res_we),
    .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_fails++;
    $display("FAIL R11 watchdog expired: actual=running expected=finished");
    finish_run();
  end

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [15:0] bpat(input int k);
    return 16'((k * 4) + (k & 3));
  endfunction

  function automatic logic [15:0] wpat(input int k);
    logic [7:0] hi, lo;
    hi = 8'((k * 8) + (k & 7));
    lo = (k & 1) ? 8'hFF : {4'(k), 4'h0};
    return {hi, lo};
  endfunction

  // reference model built from the requirement text
  task automatic model(input int op, input bit stp, input bit dn, input bit wd,
                       input bit se, input int a, input int b, input int fin,
                       output logic [15:0] r_o, output logic we_o,
                       output logic [15:0] f_o);
    int w, mask, aa, bb, ci, r, sr, cnt, f;
    bit sub, lg, c, ax, ov;
    w    = wd ? 16 : 8;
    mask = (1 << w) - 1;
    aa   = a & mask;
    if (!wd)     bb = b & 'hFF;
    else if (se) bb = (b & 'h80) ? ((b & 'hFF) | 'hFF00) : (b & 'hFF);
    else         bb = b & 'hFFFF;
    lg = 0;
    if (stp) begin
      bb = 1; sub = dn; ci = 0;
    end else begin
      sub = (op == 3) || (op == 5) || (op == 7);
      ci  = ((op == 2) || (op == 3)) ? (fin & 1) : 0;
      lg  = (op == 1) || (op == 4) || (op == 6);
    end
    if (lg) begin
      r  = (op == 1) ? (aa | bb) : (op == 4) ? (aa & bb) : (aa ^ bb);
      c = 0; ax = 0; ov = 0;
    end else if (sub) begin
      r  = aa - bb - ci;
      c  = aa < bb + ci;
      ax = (aa & 15) < (bb & 15) + ci;
      sr = sx(aa, w) - sx(bb, w) - ci;
      ov = (sr > (1 << (w - 1)) - 1) || (sr < -(1 << (w - 1)));
    end else begin
      r  = aa + bb + ci;
      c  = r > mask;
      ax = (aa & 15) + (bb & 15) + ci > 15;
      sr = sx(aa, w) + sx(bb, w) + ci;
      ov = (sr > (1 << (w - 1)) - 1) || (sr < -(1 << (w - 1)));
    end
    r = r & mask;
    cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (r >> i) & 1;
    f = fin & 'hFFFF;
    f = (f & ~'h08D5);
    if (ov)                        f |= 'h0800;
    if (r & (1 << (w - 1)))        f |= 'h0080;
    if (r == 0)                    f |= 'h0040;
    if (ax)                        f |= 'h0010;
    if ((cnt % 2) == 0)            f |= 'h0004;
    if (stp ? (fin & 1) : c)       f |= 'h0001;
    f    = (f & ~'hF02A) | 'hF002;
    r_o  = 16'(r);
    we_o = stp || (op != 7);
    f_o  = 16'(f);
  endtask

  task automatic apply(input string tag, input int op, input bit stp, input bit dn,
                       input bit wd, input bit se, input int a, input int b, input int fin);
    logic [15:0] er, ef;
    logic        ew;
    model(op, stp, dn, wd, se, a, b, fin, er, ew, ef);
    op_valid = 1'b1; op_code = 3'(op); step_sel = stp; step_down = dn;
    word_mode = wd; sext_imm = se; dst_opd = 16'(a); src_opd = 16'(b);
    flags_in = 16'(fin);
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (res_out !== er || res_we !== ew || flags_out !== ef) begin
      n_fails++;
      $display("FAIL %s op=%0d step=%0b dn=%0b w=%0b se=%0b a=%h b=%h fin=%h: actual res=%h we=%b fl=%h expected res=%h we=%b fl=%h",
               tag, op, stp, dn, wd, se, a, b, fin, res_out, res_we, flags_out, er, ew, ef);
    end
  endtask

  function automatic string op_tag(input int op);
    if (op == 7)                       return "R2/R4/R5/R6/R10";
    if (op == 2 || op == 3)            return "R3/R4/R5/R6/R10";
    if (op == 1 || op == 4 || op == 6) return "R7/R5/R10";
    return "R1/R4/R5/R6/R10";
  endfunction

  initial begin
    logic [15:0] hold_r, hold_f;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; step_sel = 0; step_down = 0;
    word_mode = 0; sext_imm = 0; dst_opd = '0; src_opd = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    n_checks++;
    if (res_out !== 16'h0 || res_we !== 1'b0 || flags_out !== 16'hF002) begin
      n_fails++;
      $display("FAIL R12 reset: actual res=%h we=%b fl=%h expected res=0000 we=0 fl=f002",
               res_out, res_we, flags_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (res_out !== 16'h0 || res_we !== 1'b0 || flags_out !== 16'hF002) begin
      n_fails++;
      $display("FAIL R12 after release: actual res=%h we=%b fl=%h expected res=0000 we=0 fl=f002",
               res_out, res_we, flags_out);
    end

    // R1 R3 R4 R5 R6 R7 R10: byte sweep
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 64; i++)
          for (int j = 0; j < 64; j++)
            apply(op_tag(op), op, 0, 0, 0, 0, int'(bpat(i)) | ((j & 3) << 8),
                  int'(bpat(j)), ((i * j * 'h1357) & 'hFFFE) | c);

    // word sweep
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 32; i++)
          for (int j = 0; j < 32; j++)
            apply(op_tag(op), op, 0, 0, 1, 0, int'(wpat(i)), int'(wpat(j)),
                  (((i + 3) * (j + 5) * 'h0F1D) & 'hFFFE) | c);

    // R8 increment/decrement, op_code deliberately varied
    for (int dn = 0; dn < 2; dn++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 256; v++) begin
          apply("R8", v & 7, 1, dn[0], 0, 0, v, 'h5A, (v * 'h2B1) & 'hFFFE | c);
          apply("R8", (v + 3) & 7, 1, dn[0], 1, 0, (v < 32) ? int'(wpat(v)) : v * 257,
                'hA5, (v * 'h0713) & 'hFFFE | c);
        end

    // R9 sign extension in word mode, ignored in byte mode
    for (int op = 0; op < 8; op++)
      for (int v = 0; v < 256; v++) begin
        apply("R9", op, 0, 0, 1, 1, int'(wpat(v & 31)), v | 'h3C00, 'h0701 & (v * 'h11));
        apply("R9", op, 0, 0, 0, 1, v, (255 - v) | 'hC300, 'h0001 & v);
      end

    // R11 idle cycles hold outputs and drop the write strobe
    apply("R11", 0, 0, 0, 1, 0, 'h1234, 'h4321, 'h0000);
    hold_r = res_out; hold_f = flags_out;
    op_valid = 1'b0; op_code = 3'd6; dst_opd = 16'hFFFF; src_opd = 16'h0F0F; flags_in = 16'h0FFF;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (res_we !== 1'b0 || res_out !== hold_r || flags_out !== hold_f) begin
        n_fails++;
        $display("FAIL R11 idle: actual res=%h we=%b fl=%h expected res=%h we=0 fl=%h",
                 res_out, res_we, flags_out, hold_r, hold_f);
      end
    end
    finish_run();
  end
endmodule